// File: doc/BRIEF.md
# Banked Program Counter Controller

This block holds the 12-bit program counter of a small controller whose 4K program space is split into two 2K banks. Bit 11 of the counter names the bank, and bits 10 to 0 address a word inside it. The block advances the counter, loads it for jumps and calls, reloads it from the return stack, and vectors it for interrupts. Decoded operation strobes arrive from the instruction decoder. The stack storage lives outside the block: the block offers the return address to push, and it receives the popped address.

Bank changes are deferred. A select strobe only records the wanted bank in a flag. The next jump or call copies that flag into bit 11. Sequential counting wraps inside the current bank and never carries into bit 11. An interrupt acknowledge sends execution to one of two fixed vectors in bank 0. Bit 11 then stays low until the return-and-restore strobe ends the service routine. A bank select made during the routine changes only the flag.

Top module: `pcb_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the counter becomes 000h and the bank flag is cleared, so a jump made right after reset lands in bank 0.
- R2: An increment adds one to bits 10..0, which wrap from 7FFh to 000h. Bit 11 is left unchanged, so FFFh is followed by 800h.
- R3: `sel_bank1_i` sets the bank flag and `sel_bank0_i` clears it; when both are high the flag is set. Neither strobe changes the counter.
- R4: A jump or a call loads bits 10..0 from `target_i` and bit 11 from the bank flag as it stood before that edge, so a select in the same cycle takes effect only on a later branch.
- R5: `push_pc_o` always shows the address after the current one within the same bank: bit 11 of the counter above bits 10..0 plus one, wrapping in the bank.
- R6: A return loads all 12 bits from `pop_pc_i` and leaves the bank flag as it was.
- R7: An interrupt acknowledge loads 003h when `irq_vec_i` is 0 and 007h when it is 1, and starts the service state.
- R8: In the service state bit 11 of the counter is always 0. Jumps, calls and returns use 0 for bit 11, and bank selects change only the flag, which later branches use once the state ends.
- R9: A return-and-restore loads all 12 bits from `pop_pc_i`, including bit 11, and ends the service state.
- R10: When several flow strobes are high in one cycle, exactly one acts, in this order: interrupt acknowledge, return-and-restore, return, call, jump, increment. Bank selects act alongside any of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inc_i | input | 1 | Advance the counter |
| jump_i | input | 1 | Jump to the branch target |
| call_i | input | 1 | Call the branch target |
| ret_i | input | 1 | Return from subroutine |
| retr_i | input | 1 | Return and restore, ending the service routine |
| sel_bank0_i | input | 1 | Request bank 0 for the next branch |
| sel_bank1_i | input | 1 | Request bank 1 for the next branch |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| irq_vec_i | input | 1 | Vector choice: 0 gives 003h, 1 gives 007h |
| target_i | input | 11 | Branch target within a bank |
| pop_pc_i | input | 12 | Address popped from the return stack |
| pc_o | output | 12 | Current program counter |
| push_pc_o | output | 12 | Return address to push |

## Verification
The counter, the bank flag and the service state are registers. A strobe applied in the cycle before a rising edge therefore shows on `pc_o` right after that edge, one cycle later. `push_pc_o` is combinational from the counter, so it changes in the same window. The bench drives strobes on the falling edge, holds them across exactly one rising edge, clears them on the next falling edge, and reads the outputs at that same falling edge. The flag has no port of its own, so its value is read through the bit 11 that a later jump produces.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    // Flow operation chosen for one cycle, after priority resolution
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_INC,
        OP_JMP,
        OP_CALL,
        OP_RET,
        OP_RETR,
        OP_IRQ
    } flow_op_e;

    typedef struct packed {
        logic irq;
        logic retr;
        logic ret;
        logic call;
        logic jmp;
        logic inc;
    } flow_req_t;

    // Highest-priority strobe wins (R10)
    function automatic flow_op_e pick_op(input flow_req_t r);
        if (r.irq)       return OP_IRQ;
        else if (r.retr) return OP_RETR;
        else if (r.ret)  return OP_RET;
        else if (r.call) return OP_CALL;
        else if (r.jmp)  return OP_JMP;
        else if (r.inc)  return OP_INC;
        else             return OP_HOLD;
    endfunction

endpackage

// File: rtl/pcb_bank_flag.sv
module pcb_bank_flag (
    input  logic clk,
    input  logic rst,
    input  logic sel_lo,
    input  logic sel_hi,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (sel_hi)  flag <= 1'b1;
        else if (sel_lo)  flag <= 1'b0;
    end

    p_sel_hi_sets_r3: assert property (@(posedge clk) disable iff (rst)
        sel_hi |=> flag);
    p_sel_lo_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (sel_lo && !sel_hi) |=> !flag);
    p_flag_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (!sel_lo && !sel_hi) |=> $stable(flag));

endmodule

// File: rtl/pcb_isr_state.sv
module pcb_isr_state
    import pcb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  flow_op_e op,
    output logic     in_isr
);

    always_ff @(posedge clk) begin
        if (rst)                 in_isr <= 1'b0;
        else if (op == OP_IRQ)   in_isr <= 1'b1;
        else if (op == OP_RETR)  in_isr <= 1'b0;
    end

    p_isr_entry_r7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IRQ) |=> in_isr);
    p_isr_exit_r9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RETR) |=> !in_isr);

endmodule

// File: rtl/pcb_pc_reg.sv
module pcb_pc_reg
    import pcb_pkg::*;
#(
    parameter int unsigned PC_W   = 12,
    parameter int unsigned VEC_LO = 3,
    parameter int unsigned VEC_HI = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  flow_op_e        op,
    input  logic            bank_flag,
    input  logic            in_isr,
    input  logic            vec_sel,
    input  logic [PC_W-2:0] target,
    input  logic [PC_W-1:0] pop_pc,
    output logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] ret_addr
);

    localparam int unsigned OFS_W = PC_W - 1;
    localparam logic [PC_W-1:0] VEC_A = PC_W'(VEC_LO);
    localparam logic [PC_W-1:0] VEC_B = PC_W'(VEC_HI);

    logic [OFS_W-1:0] ofs_inc;
    logic             branch_bank;
    logic [PC_W-1:0]  pc_nxt;

    assign ofs_inc     = pc[OFS_W-1:0] + 1'b1;
    assign branch_bank = bank_flag & ~in_isr;
    assign ret_addr    = {pc[OFS_W], ofs_inc};

    always_comb begin
        pc_nxt = pc;
        unique case (op)
            OP_INC:          pc_nxt = {pc[OFS_W], ofs_inc};
            OP_JMP, OP_CALL: pc_nxt = {branch_bank, target};
            OP_RET:          pc_nxt = {pop_pc[OFS_W] & ~in_isr, pop_pc[OFS_W-1:0]};
            OP_RETR:         pc_nxt = pop_pc;
            OP_IRQ:          pc_nxt = vec_sel ? VEC_B : VEC_A;
            default:         pc_nxt = pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_nxt;
    end

    p_inc_same_bank_r2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INC) |=> (pc[OFS_W] == $past(pc[OFS_W])));
    p_branch_bank_r4: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_JMP || op == OP_CALL) && !in_isr)
            |=> (pc[OFS_W] == $past(bank_flag)));
    p_vector_r7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IRQ) |=> (pc == VEC_A || pc == VEC_B));
    p_retr_full_r9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RETR) |=> (pc == $past(pop_pc)));

endmodule

// File: rtl/pcb_ctrl.sv
module pcb_ctrl
    import pcb_pkg::*;
#(
    parameter int unsigned PC_W   = 12,
    parameter int unsigned VEC_LO = 3,
    parameter int unsigned VEC_HI = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            inc_i,
    input  logic            jump_i,
    input  logic            call_i,
    input  logic            ret_i,
    input  logic            retr_i,
    input  logic            sel_bank0_i,
    input  logic            sel_bank1_i,
    input  logic            irq_ack_i,
    input  logic            irq_vec_i,
    input  logic [PC_W-2:0] target_i,
    input  logic [PC_W-1:0] pop_pc_i,
    output logic [PC_W-1:0] pc_o,
    output logic [PC_W-1:0] push_pc_o
);

    flow_req_t req;
    flow_op_e  op;
    logic      bank_flag;
    logic      in_isr;

    assign req = '{irq: irq_ack_i, retr: retr_i, ret: ret_i,
                   call: call_i, jmp: jump_i, inc: inc_i};
    assign op  = pick_op(req);

    pcb_bank_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .sel_lo (sel_bank0_i),
        .sel_hi (sel_bank1_i),
        .flag   (bank_flag)
    );

    pcb_isr_state u_isr (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .in_isr (in_isr)
    );

    pcb_pc_reg #(
        .PC_W   (PC_W),
        .VEC_LO (VEC_LO),
        .VEC_HI (VEC_HI)
    ) u_pc (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .bank_flag (bank_flag),
        .in_isr    (in_isr),
        .vec_sel   (irq_vec_i),
        .target    (target_i),
        .pop_pc    (pop_pc_i),
        .pc        (pc_o),
        .ret_addr  (push_pc_o)
    );

    p_isr_bank0_r8: assert property (@(posedge clk) disable iff (rst)
        in_isr |-> !pc_o[PC_W-1]);
    p_one_op_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_ack_i && retr_i) |=> in_isr);

endmodule

// File: tb/pcb_ctrl_tb.sv
module pcb_ctrl_tb_top;

    localparam int S_INC  = 1;
    localparam int S_JMP  = 2;
    localparam int S_CALL = 4;
    localparam int S_RET  = 8;
    localparam int S_RETR = 16;
    localparam int S_SEL0 = 32;
    localparam int S_SEL1 = 64;
    localparam int S_IRQ  = 128;
    localparam int S_VEC  = 256;

    logic        clk = 1'b0;
    logic        rst;
    logic        inc_i, jump_i, call_i, ret_i, retr_i;
    logic        sel_bank0_i, sel_bank1_i, irq_ack_i, irq_vec_i;
    logic [10:0] target_i;
    logic [11:0] pop_pc_i;
    logic [11:0] pc_o, push_pc_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pcb_ctrl dut_i (
        .clk(clk), .rst(rst), .inc_i(inc_i), .jump_i(jump_i), .call_i(call_i),
        .ret_i(ret_i), .retr_i(retr_i), .sel_bank0_i(sel_bank0_i),
        .sel_bank1_i(sel_bank1_i), .irq_ack_i(irq_ack_i), .irq_vec_i(irq_vec_i),
        .target_i(target_i), .pop_pc_i(pop_pc_i), .pc_o(pc_o), .push_pc_o(push_pc_o)
    );

    task automatic drive(input int m, input logic [10:0] tgt, input logic [11:0] pop);
        inc_i       = (m & S_INC)  != 0;
        jump_i      = (m & S_JMP)  != 0;
        call_i      = (m & S_CALL) != 0;
        ret_i       = (m & S_RET)  != 0;
        retr_i      = (m & S_RETR) != 0;
        sel_bank0_i = (m & S_SEL0) != 0;
        sel_bank1_i = (m & S_SEL1) != 0;
        irq_ack_i   = (m & S_IRQ)  != 0;
        irq_vec_i   = (m & S_VEC)  != 0;
        target_i    = tgt;
        pop_pc_i    = pop;
    endtask

    // Apply strobes for one rising edge; return at the following falling edge
    task automatic step(input int m, input logic [10:0] tgt, input logic [11:0] pop);
        drive(m, tgt, pop);
        @(posedge clk);
        @(negedge clk);
        drive(0, 11'h000, 12'h000);
    endtask

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%03h expected=%03h", req, act, exp);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        drive(0, 11'h000, 12'h000);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 pc after reset", pc_o, 12'h000);
        check("R5 push after reset", push_pc_o, 12'h001);
        step(S_JMP, 11'h0AA, 12'h000);
        check("R1 flag clear after reset", pc_o, 12'h0AA);
    endtask

    task automatic t_increment;
        step(S_JMP, 11'h000, 12'h000);
        for (int k = 0; k < 3; k++) step(S_INC, 11'h000, 12'h000);
        check("R2 three increments", pc_o, 12'h003);
        step(S_JMP, 11'h7FF, 12'h000);
        check("R5 push wraps bank0", push_pc_o, 12'h000);
        step(S_INC, 11'h000, 12'h000);
        check("R2 wrap in bank0", pc_o, 12'h000);
    endtask

    task automatic t_bank_select;
        step(S_SEL1, 11'h000, 12'h000);
        check("R3 select1 leaves pc", pc_o, 12'h000);
        step(S_JMP, 11'h123, 12'h000);
        check("R4 jump into bank1", pc_o, 12'h923);
        step(S_JMP, 11'h7FF, 12'h000);
        check("R5 push wraps bank1", push_pc_o, 12'h800);
        step(S_INC, 11'h000, 12'h000);
        check("R2 FFF to 800", pc_o, 12'h800);
        step(S_SEL0, 11'h000, 12'h000);
        check("R3 select0 leaves pc", pc_o, 12'h800);
        check("R5 push at 800", push_pc_o, 12'h801);
        step(S_CALL, 11'h010, 12'h000);
        check("R4 call into bank0", pc_o, 12'h010);
        step(S_SEL0 | S_SEL1, 11'h000, 12'h000);
        step(S_JMP, 11'h020, 12'h000);
        check("R3 both selects set flag", pc_o, 12'h820);
        step(S_SEL0, 11'h000, 12'h000);
    endtask

    task automatic t_same_cycle;
        step(S_SEL1 | S_JMP, 11'h055, 12'h000);
        check("R4 same-cycle select uses old flag", pc_o, 12'h055);
        step(S_JMP, 11'h055, 12'h000);
        check("R4 select applies to later jump", pc_o, 12'h855);
    endtask

    task automatic t_return;
        step(S_RET, 11'h000, 12'h3A4);
        check("R6 return restores 12 bits", pc_o, 12'h3A4);
        step(S_JMP, 11'h001, 12'h000);
        check("R6 return keeps flag", pc_o, 12'h801);
    endtask

    task automatic t_interrupt;
        step(S_IRQ, 11'h000, 12'h000);
        check("R7 vector 003", pc_o, 12'h003);
        step(S_INC, 11'h000, 12'h000);
        check("R2 increment in service", pc_o, 12'h004);
        step(S_JMP, 11'h200, 12'h000);
        check("R8 jump stays in bank0", pc_o, 12'h200);
        step(S_SEL0, 11'h000, 12'h000);
        check("R8 select in service leaves pc", pc_o, 12'h200);
        step(S_SEL1, 11'h000, 12'h000);
        step(S_CALL, 11'h321, 12'h000);
        check("R8 call stays in bank0", pc_o, 12'h321);
        step(S_SEL0, 11'h000, 12'h000);
        step(S_RET, 11'h000, 12'hABC);
        check("R8 return stays in bank0", pc_o, 12'h2BC);
        step(S_RETR, 11'h000, 12'h9AB);
        check("R9 restore all 12 bits", pc_o, 12'h9AB);
        step(S_JMP, 11'h100, 12'h000);
        check("R8 flag from service used later", pc_o, 12'h100);
        step(S_IRQ | S_VEC, 11'h000, 12'h000);
        check("R7 vector 007", pc_o, 12'h007);
        step(S_RETR, 11'h000, 12'h802);
        check("R9 restore to bank1", pc_o, 12'h802);
    endtask

    task automatic t_priority;
        step(S_IRQ | S_JMP | S_INC | S_RETR, 11'h444, 12'h555);
        check("R10 irq wins", pc_o, 12'h003);
        step(S_RETR | S_CALL | S_RET, 11'h444, 12'h000);
        check("R10 retr beats call", pc_o, 12'h000);
        step(S_RET | S_CALL, 11'h444, 12'h111);
        check("R10 ret beats call", pc_o, 12'h111);
        step(S_CALL | S_JMP | S_INC, 11'h222, 12'h000);
        check("R10 call beats increment", pc_o, 12'h222);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_increment();
        t_bank_select();
        t_same_cycle();
        t_return();
        t_interrupt();
        t_priority();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule